// File: doc/BRIEF.md
# DMA Stream Event Flag Bank

This block gathers the per-stream event pulses of a multi-stream DMA engine into sticky flags and presents them to software as packed 32-bit status words. Each stream raises five kinds of event: transfer done, halfway reached, transfer fault, direct-mode fault and FIFO fault. Four streams share one status word, so the default eight streams occupy two words. Within a word, the four stream groups sit at uneven bit offsets, and each group leaves one bit unused.

Software reads the status words through a registered read port. It clears flags by writing ones into separate clear words, one clear word for each status word. The block also drives one interrupt line for each stream. That line is raised when any flag of the stream is set and its matching per-flag enable is high. A per-stream fault line reports whether any of the three fault flags of the stream is set. The enables do not affect this line.

Top module: `dma_evflag_bank`

## Requirements
- R1: After synchronous reset every flag is clear, so `irq`, `err` and `rd_data` are all zero.
- R2: A one-cycle pulse on an event input sets the matching flag on the next clock edge. The flag stays set after the pulse ends and stays set until software clears it.
- R3: Streams 0 to 3 are reported in status word 0 (address 0) and streams 4 to 7 in status word 1 (address 1). The group of the stream whose index modulo 4 is 0, 1, 2 or 3 starts at bit 0, 6, 16 or 22 of its word.
- R4: Within a group, done is bit 5, halfway is bit 4, transfer fault is bit 3, direct-mode fault is bit 2 and FIFO fault is bit 0. Bit 1 of each group, and every word bit outside the groups, reads 0. With all flags set, each status word reads 0x0F7D0F7D.
- R5: Writing a word to clear address 2 clears each flag of status word 0 whose bit is 1 in that word. Clear address 3 does the same for status word 1. Bits written as 0 leave their flags unchanged.
- R6: If an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R7: A read of either clear address returns 0. A write to a status address (0 or 1) changes no flag.
- R8: `irq[s]` is high exactly when at least one flag of stream s is set and its enable bit for stream s is high. An enable change shows on `irq` in the same cycle.
- R9: `err[s]` is high exactly when the transfer fault, direct-mode fault or FIFO fault flag of stream s is set, whatever the enables.
- R10: When `rd_en` is high, `rd_data` captures the addressed word on the clock edge. When `rd_en` is low, `rd_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | NUM_STREAMS | Transfer-done pulses, one per stream |
| evt_half | input | NUM_STREAMS | Halfway pulses |
| evt_xerr | input | NUM_STREAMS | Transfer-fault pulses |
| evt_dmerr | input | NUM_STREAMS | Direct-mode-fault pulses |
| evt_ferr | input | NUM_STREAMS | FIFO-fault pulses |
| ien_done | input | NUM_STREAMS | Interrupt enables for done flags |
| ien_half | input | NUM_STREAMS | Interrupt enables for halfway flags |
| ien_xerr | input | NUM_STREAMS | Interrupt enables for transfer-fault flags |
| ien_dmerr | input | NUM_STREAMS | Interrupt enables for direct-mode-fault flags |
| ien_ferr | input | NUM_STREAMS | Interrupt enables for FIFO-fault flags |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write data (ones clear flags) |
| irq | output | NUM_STREAMS | Per-stream interrupt |
| err | output | NUM_STREAMS | Per-stream fault summary |

## Verification
The hardest case to reach from the ports is a set pulse and a clear write that hit the same flag in the same cycle. The bench drives both in one task on a single falling edge, so they share a rising edge. In that same write it also clears a second, older flag, which shows that the rest of the clear still takes effect. Each flag position of every stream is also set and cleared one at a time. Each status word is read with all flags set, so that a wrong lane offset or a stray reserved bit shows up in the packed value.

// File: rtl/dmaflag_pkg.sv
package dmaflag_pkg;

    localparam int GRP_W          = 6;
    localparam int LANES_PER_WORD = 4;
    localparam int WORD_W         = 32;
    localparam logic [GRP_W-1:0] GRP_VALID = 6'b111101;

    typedef struct packed {
        logic done;
        logic half;
        logic xerr;
        logic dmerr;
        logic ferr;
    } evgrp_t;

    // Lane offsets 0, 6, 16, 22: lanes 2 and 3 skip a 4-bit gap.
    function automatic int grp_offset(int lane);
        return lane * GRP_W + ((lane >= 2) ? 4 : 0);
    endfunction

    function automatic logic [GRP_W-1:0] grp_to_bits(evgrp_t g);
        return {g.done, g.half, g.xerr, g.dmerr, 1'b0, g.ferr};
    endfunction

    function automatic evgrp_t bits_to_grp(logic [GRP_W-1:0] b);
        evgrp_t g;
        g.done  = b[5];
        g.half  = b[4];
        g.xerr  = b[3];
        g.dmerr = b[2];
        g.ferr  = b[0];
        return g;
    endfunction

endpackage

// File: rtl/dmaflag_cell.sv
module dmaflag_cell
    import dmaflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evgrp_t           set_i,
    input  logic [GRP_W-1:0] clr_i,
    input  evgrp_t           en_i,
    output evgrp_t           flags_o,
    output logic             irq_o,
    output logic             err_o
);
    logic [GRP_W-1:0] q;
    logic [GRP_W-1:0] nxt;

    always_comb begin
        // set dominates clear
        nxt = (grp_to_bits(set_i) | (q & ~clr_i)) & GRP_VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    always_comb begin
        flags_o = bits_to_grp(q);
        irq_o   = |(flags_o & en_i);
        err_o   = flags_o.xerr | flags_o.dmerr | flags_o.ferr;
    end
endmodule

// File: rtl/dmaflag_pack.sv
module dmaflag_pack
    import dmaflag_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    localparam int NUM_WORDS  = NUM_STREAMS / LANES_PER_WORD
) (
    input  evgrp_t                   flags_i [NUM_STREAMS],
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words_o
);
    always_comb begin
        words_o = '0;
        for (int s = 0; s < NUM_STREAMS; s++) begin
            words_o[s / LANES_PER_WORD][grp_offset(s % LANES_PER_WORD) +: GRP_W]
                = grp_to_bits(flags_i[s]);
        end
    end
endmodule

// File: rtl/dmaflag_regport.sv
module dmaflag_regport
    import dmaflag_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [WORD_W-1:0]            rd_data,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] stat_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] clr_o
);
    logic [WORD_W-1:0] rd_mux;

    // status words readable; clear words read zero
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_addr == ADDR_W'(w)) rd_mux = stat_i[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
            always_comb begin
                clr_o[w] = (wr_en && wr_addr == ADDR_W'(NUM_WORDS + w)) ? wr_data : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/dma_evflag_bank.sv
module dma_evflag_bank
    import dmaflag_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    localparam int NUM_WORDS  = NUM_STREAMS / LANES_PER_WORD,
    localparam int ADDR_W     = $clog2(2 * NUM_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] evt_done,
    input  logic [NUM_STREAMS-1:0] evt_half,
    input  logic [NUM_STREAMS-1:0] evt_xerr,
    input  logic [NUM_STREAMS-1:0] evt_dmerr,
    input  logic [NUM_STREAMS-1:0] evt_ferr,
    input  logic [NUM_STREAMS-1:0] ien_done,
    input  logic [NUM_STREAMS-1:0] ien_half,
    input  logic [NUM_STREAMS-1:0] ien_xerr,
    input  logic [NUM_STREAMS-1:0] ien_dmerr,
    input  logic [NUM_STREAMS-1:0] ien_ferr,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [WORD_W-1:0]      rd_data,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    output logic [NUM_STREAMS-1:0] irq,
    output logic [NUM_STREAMS-1:0] err
);
    evgrp_t flags [NUM_STREAMS];
    logic [NUM_WORDS-1:0][WORD_W-1:0] stat_words;
    logic [NUM_WORDS-1:0][WORD_W-1:0] clr_words;

    generate
        for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
            evgrp_t set_g, en_g;
            logic [GRP_W-1:0] clr_g;
            always_comb begin
                set_g = '{done: evt_done[s], half: evt_half[s], xerr: evt_xerr[s],
                          dmerr: evt_dmerr[s], ferr: evt_ferr[s]};
                en_g  = '{done: ien_done[s], half: ien_half[s], xerr: ien_xerr[s],
                          dmerr: ien_dmerr[s], ferr: ien_ferr[s]};
                clr_g = clr_words[s / LANES_PER_WORD][grp_offset(s % LANES_PER_WORD) +: GRP_W];
            end
            dmaflag_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .set_i   (set_g),
                .clr_i   (clr_g),
                .en_i    (en_g),
                .flags_o (flags[s]),
                .irq_o   (irq[s]),
                .err_o   (err[s])
            );
        end
    endgenerate

    dmaflag_pack #(.NUM_STREAMS(NUM_STREAMS)) u_pack (
        .flags_i (flags),
        .words_o (stat_words)
    );

    dmaflag_regport #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_port (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .stat_i  (stat_words),
        .clr_o   (clr_words)
    );
endmodule

// File: rtl/dmaflag_chk.sv
module dmaflag_chk #(
    parameter int NUM_STREAMS = 8,
    parameter int ADDR_W      = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_STREAMS-1:0] evt_done,
    input logic [NUM_STREAMS-1:0] evt_half,
    input logic [NUM_STREAMS-1:0] evt_xerr,
    input logic [NUM_STREAMS-1:0] evt_dmerr,
    input logic [NUM_STREAMS-1:0] evt_ferr,
    input logic [NUM_STREAMS-1:0] ien_done,
    input logic [NUM_STREAMS-1:0] ien_half,
    input logic [NUM_STREAMS-1:0] ien_xerr,
    input logic [NUM_STREAMS-1:0] ien_dmerr,
    input logic [NUM_STREAMS-1:0] ien_ferr,
    input logic                   rd_en,
    input logic [ADDR_W-1:0]      rd_addr,
    input logic [31:0]            rd_data,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [31:0]            wr_data,
    input logic [NUM_STREAMS-1:0] irq,
    input logic [NUM_STREAMS-1:0] err
);
    AST_RST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == '0 && err == '0 && rd_data == '0)); // R1

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R10

    generate
        for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_a
            AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
                $fell(err[i]) |-> $past(wr_en)); // R2

            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                (evt_xerr[i] || evt_dmerr[i] || evt_ferr[i]) |=> err[i]); // R6

            AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
                (evt_done[i] && ien_done[i]) ##1 ien_done[i] |-> irq[i]); // R8

            AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
                !(ien_done[i] || ien_half[i] || ien_xerr[i] || ien_dmerr[i] || ien_ferr[i])
                |-> !irq[i]); // R8
        end
    endgenerate
endmodule

bind dma_evflag_bank dmaflag_chk #(.NUM_STREAMS(NUM_STREAMS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dma_evflag_bank.sv
`timescale 1ns/1ps
module sim_dma_evflag_bank;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0] evt_done = '0, evt_half = '0, evt_xerr = '0, evt_dmerr = '0, evt_ferr = '0;
    logic [NS-1:0] ien_done = '0, ien_half = '0, ien_xerr = '0, ien_dmerr = '0, ien_ferr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  rd_addr = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NS-1:0] irq, err;

    int ntest = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    dma_evflag_bank #(.NUM_STREAMS(NS)) u0 (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        ntest++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // kinds: 0 done, 1 half, 2 xerr, 3 dmerr, 4 ferr
    function automatic logic [31:0] exp_bit(int s, int k);
        int offs, bp;
        case (s % 4)
            0: offs = 0;
            1: offs = 6;
            2: offs = 16;
            default: offs = 22;
        endcase
        case (k)
            0: bp = 5;
            1: bp = 4;
            2: bp = 3;
            3: bp = 2;
            default: bp = 0;
        endcase
        return 32'd1 << (offs + bp);
    endfunction

    task automatic set_evt(int s, int k, logic v);
        case (k)
            0: evt_done[s]  = v;
            1: evt_half[s]  = v;
            2: evt_xerr[s]  = v;
            3: evt_dmerr[s] = v;
            default: evt_ferr[s] = v;
        endcase
    endtask

    task automatic pulse(int s, int k);
        @(negedge clk); set_evt(s, k, 1'b1);
        @(negedge clk); set_evt(s, k, 1'b0);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 err after reset", 32'(err), 32'h0);
        chk("R1 rd_data after reset", rd_data, 32'h0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 word after reset", d, 32'h0);
        end
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(0, 0);
        repeat (3) @(negedge clk);
        rd(2'd0, d);
        chk("R2 done flag sticky", d, 32'h20);
        rd(2'd0, d);
        chk("R2 done flag still set", d, 32'h20);
        wr(2'd2, 32'h20);
        rd(2'd0, d);
        chk("R5 done flag cleared", d, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 5; k++) begin
                pulse(s, k);
                rd(2'(s / 4), d);
                chk($sformatf("R3 R4 stream %0d kind %0d", s, k), d, exp_bit(s, k));
                rd(2'(1 - s / 4), d);
                chk("R3 other word empty", d, 32'h0);
                wr(2'(2 + s / 4), exp_bit(s, k));
                rd(2'(s / 4), d);
                chk("R5 single flag cleared", d, 32'h0);
            end
        end
    endtask

    task automatic t_full_words();
        logic [31:0] d, full;
        full = '0;
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 5; k++) full |= exp_bit(s, k);
        @(negedge clk);
        evt_done = '1; evt_half = '1; evt_xerr = '1; evt_dmerr = '1; evt_ferr = '1;
        @(negedge clk);
        evt_done = '0; evt_half = '0; evt_xerr = '0; evt_dmerr = '0; evt_ferr = '0;
        chk("R4 packed mask value", full, 32'h0F7D0F7D);
        rd(2'd0, d); chk("R4 low word all set", d, full);
        rd(2'd1, d); chk("R4 high word all set", d, full);
        wr(2'd2, 32'h0);
        rd(2'd0, d); chk("R5 zero clear no effect", d, full);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R7 status write ignored lo", d, full);
        rd(2'd1, d); chk("R7 status write ignored hi", d, full);
        rd(2'd2, d); chk("R7 clear word lo reads 0", d, 32'h0);
        rd(2'd3, d); chk("R7 clear word hi reads 0", d, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R5 low clear", d, 32'h0);
        rd(2'd1, d); chk("R5 high untouched", d, full);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R5 high clear", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(4, 0);
        @(negedge clk);
        evt_xerr[5] = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = exp_bit(5, 2) | exp_bit(4, 0);
        @(negedge clk);
        evt_xerr[5] = 1'b0; wr_en = 1'b0; wr_data = '0;
        rd(2'd1, d);
        chk("R6 set beats clear", d, exp_bit(5, 2));
        wr(2'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        ien_half[2] = 1'b1;
        pulse(2, 0);
        chk("R8 disabled flag no irq", 32'(irq), 32'h0);
        pulse(2, 1);
        chk("R8 enabled flag irq", 32'(irq), 32'h4);
        @(negedge clk); ien_half[2] = 1'b0; #1;
        chk("R8 enable drop", 32'(irq), 32'h0);
        ien_done[2] = 1'b1; #1;
        chk("R8 other enable raises", 32'(irq), 32'h4);
        wr(2'd2, exp_bit(2, 0) | exp_bit(2, 1));
        chk("R8 clear drops irq", 32'(irq), 32'h0);
        ien_done[2] = 1'b0;
    endtask

    task automatic t_err();
        pulse(7, 4);
        chk("R9 fifo fault err", 32'(err), 32'h80);
        pulse(6, 0);
        chk("R9 done is not fault", 32'(err), 32'h80);
        pulse(1, 3);
        chk("R9 dm fault err", 32'(err), 32'h82);
        chk("R9 no irq without enables", 32'(irq), 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        chk("R9 err cleared", 32'(err), 32'h0);
    endtask

    task automatic t_rd_hold();
        logic [31:0] d;
        pulse(3, 1);
        rd(2'd0, d);
        chk("R10 read value", d, exp_bit(3, 1));
        pulse(0, 4);
        repeat (2) @(negedge clk);
        chk("R10 rd_data held", rd_data, exp_bit(3, 1));
        rd(2'd0, d);
        chk("R10 fresh read", d, exp_bit(3, 1) | exp_bit(0, 4));
        wr(2'd2, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sticky();
        t_layout();
        t_full_words();
        t_set_wins();
        t_irq();
        t_err();
        t_rd_hold();
        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        nfail++;
        ntest++;
        $display("FAIL watchdog expired (all requirements) got=hang exp=finish");
        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule